// File: doc/BRIEF.md
# Half-Slot Native Clock Counter

This block keeps the local native time of a short-range frequency-hopping radio link. A 28-bit counter advances once per half-slot (312.5 µs), so two increments make one slot. At full power the count is derived from a reference oscillator. A divider turns the reference into a 125 ns timebase, and a modulo-2500 phase counter turns that timebase into half-slots. The divide ratio comes from two strap pins that are captured while reset is held. Each increment drives a slot-boundary tick that stays high for a programmable number of reference cycles, so the pulse can be made wider than 100 ns.

Link control can make three requests. It can overwrite the low 12 bits of the count, which is used when the unit adopts a slave timing. It can send the unit into a low-power sleep, in which a slow external strobe keeps the count running and wakes the block when the low 12 bits reach a programmed mark. It can measure the skew between a recovered slave timing point and the local master position, which is reported as a clamped signed value in 125 ns units.

All inputs are plain control pins sampled on the reference clock. The skew result is a one-cycle `skew_valid` pulse with no back-pressure, so a consumer must capture it in that cycle. The slow strobe `lp_pulse` is expected to be already synchronized to `clk` as a single-cycle pulse.

Top module: `halfslot_clock`

## Requirements
- R1: While reset is held and after its release, `native_cnt` is 0, `tick` is low, `hf_on` and `ready` are high, and `skew_valid` and `skew_ovf` are low.
- R2: The straps are captured only while `rst_n` is low: 00 selects divide by 2, 01 divide by 3, 10 divide by 4, and 11 divide by 2. At full power, consecutive increments are exactly D×HALF_SLOT reference cycles apart. A strap change after reset has no effect.
- R3: Each increment adds 1 to `native_cnt`, modulo 2^28. In the same cycle `tick` rises, and it stays high for TICK_W cycles.
- R4: `cmd_load` with `load_en`=1 replaces bits 11:0 of the count with `load_val` in the next cycle and leaves bits 27:12 unchanged. When a load and an increment fall in the same cycle, the load wins.
- R5: `cmd_load` with `load_en`=0 leaves the count unchanged.
- R6: An increment from a low field of 0xFFF carries into bit 12.
- R7: `pd_req` in full power drops `hf_on` and `ready`. While asleep, one increment occurs per LP_DIV pulses of `lp_pulse`.
- R8: A sleep increment whose new low 12 bits equal `wake_mark` raises `hf_on` and restarts the reference timebase from phase 0. `ready` rises at the third increment after that.
- R9: A `sync_strobe` while not asleep produces `skew` = `slave_pos` − master position. The master position is `native_cnt[0]`×HALF_SLOT plus the current phase. The result appears with a one-cycle `skew_valid` in the next cycle.
- R10: A skew value outside ±(HALF_SLOT−1) is clamped to the nearer limit, and `skew_ovf` is then set and stays set until reset. Values exactly at a limit do not set it.
- R11: A `sync_strobe` while asleep is ignored: `skew_valid` stays low and `skew` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while it is low |
| strap | input | 2 | Divider select straps |
| lp_pulse | input | 1 | One-cycle strobe from the slow oscillator |
| cmd_load | input | 1 | Load command strobe |
| load_en | input | 1 | Load flag; the load happens only when it is 1 |
| load_val | input | LOW_W | New value for the low count bits |
| pd_req | input | 1 | Enter sleep |
| wake_mark | input | LOW_W | Low-bit value that ends sleep |
| sync_strobe | input | 1 | Recovered slave timing point |
| slave_pos | input | POS_W | Slave position within a slot, in 125 ns units |
| native_cnt | output | CNT_W | Native half-slot count |
| tick | output | 1 | Slot-boundary pulse |
| hf_on | output | 1 | High-rate clock domain powered |
| ready | output | 1 | Full power reached |
| skew | output | SKEW_W | Signed, clamped skew |
| skew_valid | output | 1 | Skew result strobe |
| skew_ovf | output | 1 | Sticky clamp flag |

## Verification
The bench measures the spacing between increments for every strap code, including the unused code 11. It changes the straps after release, so a divider that reads live straps or maps 11 wrongly shows up as a wrong interval. It loads 0xFFF and then waits for the next increment to catch a carry that is lost between the two count fields, and it issues a load with the flag clear to catch a counter that ignores the flag. Skew is driven exactly at both limits and one step beyond each, which exposes off-by-one clamps and an overflow flag that is set at a limit or is not sticky. The sleep sequence checks the wake on the mark match, the restart at full power, and the three-increment delay before `ready`. It also checks that a strobe during sleep is ignored.

// File: rtl/hsclk_pkg.sv
package hsclk_pkg;

  typedef enum logic [1:0] {
    PWR_ACTIVE = 2'd0,
    PWR_SLEEP  = 2'd1,
    PWR_WAKE   = 2'd2
  } pwr_state_e;

  // Strap code to reference divide ratio; code 11 falls back to divide by 2
  function automatic logic [2:0] strap_to_div(logic [1:0] code);
    case (code)
      2'b01:   return 3'd3;
      2'b10:   return 3'd4;
      default: return 3'd2;
    endcase
  endfunction

endpackage

// File: rtl/hs_ref_divider.sv
module hs_ref_divider
  import hsclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] strap,
  input  logic       restart,
  output logic       ce
);

  logic [1:0] sel_q;
  logic [1:0] cnt_q;
  logic [1:0] last;

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= strap;
  end

  assign last = 2'(strap_to_div(sel_q) - 3'd1);
  assign ce   = (cnt_q == last);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt_q <= '0;
    else if (ce)           cnt_q <= '0;
    else                   cnt_q <= cnt_q + 2'd1;
  end

  // R2
  ce_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce |=> !ce);

endmodule

// File: rtl/hs_phase_gen.sv
module hs_phase_gen #(
  parameter int HALF_SLOT = 2500,
  parameter int LP_DIV    = 40,
  localparam int PH_W     = $clog2(HALF_SLOT),
  localparam int LP_W     = $clog2(LP_DIV)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce,
  input  logic            lp_pulse,
  input  logic            sleep,
  input  logic            restart,
  output logic            inc,
  output logic [PH_W-1:0] phase
);

  logic [LP_W-1:0] lp_cnt_q;
  logic            hs_wrap;
  logic            lp_wrap;

  assign hs_wrap = ce && (phase == PH_W'(HALF_SLOT - 1));
  assign lp_wrap = lp_pulse && (lp_cnt_q == LP_W'(LP_DIV - 1));
  assign inc     = sleep ? lp_wrap : hs_wrap;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      phase    <= '0;
      lp_cnt_q <= '0;
    end else if (sleep) begin
      if (lp_pulse) lp_cnt_q <= lp_wrap ? '0 : lp_cnt_q + LP_W'(1);
    end else if (ce) begin
      phase <= hs_wrap ? '0 : phase + PH_W'(1);
    end
  end

  // R2
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase < PH_W'(HALF_SLOT));

  // R7
  sleep_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !restart) |=> $stable(phase));

endmodule

// File: rtl/hs_power_ctrl.sv
module hs_power_ctrl
  import hsclk_pkg::*;
#(
  parameter int LOW_W      = 12,
  parameter int WAKE_TICKS = 3,
  localparam int WK_W      = $clog2(WAKE_TICKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_req,
  input  logic             inc,
  input  logic [LOW_W-1:0] low_new,
  input  logic [LOW_W-1:0] wake_mark,
  output logic             restart,
  output logic             sleep,
  output logic             hf_on,
  output logic             ready
);

  pwr_state_e      st_q;
  logic [WK_W-1:0] wk_q;
  logic            go_sleep;
  logic            wake_hit;

  assign go_sleep = (st_q == PWR_ACTIVE) && pd_req;
  assign wake_hit = (st_q == PWR_SLEEP) && inc && (low_new == wake_mark);
  assign restart  = go_sleep || wake_hit;
  assign sleep    = (st_q == PWR_SLEEP);
  assign hf_on    = !sleep;
  assign ready    = (st_q == PWR_ACTIVE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= PWR_ACTIVE;
      wk_q <= '0;
    end else begin
      case (st_q)
        PWR_ACTIVE: if (pd_req) st_q <= PWR_SLEEP;
        PWR_SLEEP: if (wake_hit) begin
          st_q <= PWR_WAKE;
          wk_q <= '0;
        end
        PWR_WAKE: if (inc) begin
          if (wk_q == WK_W'(WAKE_TICKS - 1)) st_q <= PWR_ACTIVE;
          else                               wk_q <= wk_q + WK_W'(1);
        end
        default: st_q <= PWR_ACTIVE;
      endcase
    end
  end

  // R7
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hf_on) |-> $past(pd_req));

  // R8
  wake_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hf_on) |-> $past(inc && (low_new == wake_mark)));

  // R8
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(inc));

endmodule

// File: rtl/hs_skew_meter.sv
module hs_skew_meter #(
  parameter int HALF_SLOT = 2500,
  parameter int POS_W     = 13,
  parameter int SKEW_W    = 13,
  localparam int DIFF_W   = POS_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              enable,
  input  logic [POS_W-1:0]  slave_pos,
  input  logic [POS_W-1:0]  master_pos,
  output logic [SKEW_W-1:0] skew,
  output logic              valid,
  output logic              ovf
);

  localparam logic signed [DIFF_W-1:0] LIM_P = DIFF_W'(HALF_SLOT - 1);
  localparam logic signed [DIFF_W-1:0] LIM_N = -LIM_P;
  localparam logic signed [SKEW_W-1:0] LIM_S = SKEW_W'(HALF_SLOT - 1);

  logic signed [DIFF_W-1:0] diff;
  logic signed [DIFF_W-1:0] clamped;
  logic                     over;
  logic                     take;

  assign take = strobe && enable;
  assign diff = $signed({2'b00, slave_pos}) - $signed({2'b00, master_pos});

  always_comb begin
    over    = 1'b0;
    clamped = diff;
    if (diff > LIM_P) begin
      clamped = LIM_P;
      over    = 1'b1;
    end else if (diff < LIM_N) begin
      clamped = LIM_N;
      over    = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      skew  <= '0;
      valid <= 1'b0;
      ovf   <= 1'b0;
    end else begin
      valid <= take;
      if (take) begin
        skew <= clamped[SKEW_W-1:0];
        if (over) ovf <= 1'b1;
      end
    end
  end

  // R10
  skew_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ($signed(skew) <= LIM_S && $signed(skew) >= -LIM_S));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  // R11
  valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(strobe && enable));

endmodule

// File: rtl/halfslot_clock.sv
module halfslot_clock #(
  parameter int CNT_W      = 28,
  parameter int LOW_W      = 12,
  parameter int HALF_SLOT  = 2500,
  parameter int LP_DIV     = 40,
  parameter int TICK_W     = 2,
  parameter int WAKE_TICKS = 3,
  localparam int POS_W     = $clog2(2 * HALF_SLOT),
  localparam int SKEW_W    = $clog2(HALF_SLOT) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        strap,
  input  logic              lp_pulse,
  input  logic              cmd_load,
  input  logic              load_en,
  input  logic [LOW_W-1:0]  load_val,
  input  logic              pd_req,
  input  logic [LOW_W-1:0]  wake_mark,
  input  logic              sync_strobe,
  input  logic [POS_W-1:0]  slave_pos,
  output logic [CNT_W-1:0]  native_cnt,
  output logic              tick,
  output logic              hf_on,
  output logic              ready,
  output logic [SKEW_W-1:0] skew,
  output logic              skew_valid,
  output logic              skew_ovf
);

  localparam int PH_W = $clog2(HALF_SLOT);
  localparam int TW   = $clog2(TICK_W + 1);

  logic             ce, inc, restart, sleep, ld;
  logic [PH_W-1:0]  phase;
  logic [CNT_W-1:0] cnt_q, cnt_next;
  logic [TW-1:0]    tick_cnt_q;
  logic [POS_W-1:0] master_pos;

  hs_ref_divider u_div (
    .clk(clk), .rst_n(rst_n), .strap(strap), .restart(restart), .ce(ce)
  );

  hs_phase_gen #(.HALF_SLOT(HALF_SLOT), .LP_DIV(LP_DIV)) u_phase (
    .clk(clk), .rst_n(rst_n), .ce(ce), .lp_pulse(lp_pulse), .sleep(sleep),
    .restart(restart), .inc(inc), .phase(phase)
  );

  assign ld = cmd_load && load_en;

  always_comb begin
    cnt_next = cnt_q;
    if (ld)       cnt_next = {cnt_q[CNT_W-1:LOW_W], load_val};
    else if (inc) cnt_next = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      tick_cnt_q <= '0;
    end else begin
      cnt_q <= cnt_next;
      if (inc)                   tick_cnt_q <= TW'(TICK_W);
      else if (tick_cnt_q != '0) tick_cnt_q <= tick_cnt_q - TW'(1);
    end
  end

  assign native_cnt = cnt_q;
  assign tick       = (tick_cnt_q != '0);

  hs_power_ctrl #(.LOW_W(LOW_W), .WAKE_TICKS(WAKE_TICKS)) u_pwr (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .inc(inc),
    .low_new(cnt_next[LOW_W-1:0]), .wake_mark(wake_mark), .restart(restart),
    .sleep(sleep), .hf_on(hf_on), .ready(ready)
  );

  assign master_pos = POS_W'(phase) + (cnt_q[0] ? POS_W'(HALF_SLOT) : '0);

  hs_skew_meter #(.HALF_SLOT(HALF_SLOT), .POS_W(POS_W), .SKEW_W(SKEW_W)) u_skew (
    .clk(clk), .rst_n(rst_n), .strobe(sync_strobe), .enable(!sleep),
    .slave_pos(slave_pos), .master_pos(master_pos), .skew(skew),
    .valid(skew_valid), .ovf(skew_ovf)
  );

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !ld) |=> $stable(native_cnt));

  // R3
  tick_on_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> tick);

  // R4
  load_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (native_cnt[LOW_W-1:0] == $past(load_val)));

  // R4
  load_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (native_cnt[CNT_W-1:LOW_W] == $past(native_cnt[CNT_W-1:LOW_W])));

endmodule

// File: tb/halfslot_clock_test.sv
`timescale 1ns/1ps
module halfslot_clock_test;

  localparam int HS = 10;
  localparam int LP = 4;
  localparam int LP_PERIOD = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  strap = 2'b00;
  logic        lp_pulse = 1'b0;
  logic        cmd_load = 1'b0, load_en = 1'b0;
  logic [11:0] load_val = '0, wake_mark = '0;
  logic        pd_req = 1'b0, sync_strobe = 1'b0;
  logic [4:0]  slave_pos = '0;
  logic [27:0] native_cnt;
  logic        tick, hf_on, ready, skew_valid, skew_ovf;
  logic [4:0]  skew;

  int n_checks = 0, n_fail = 0;
  int cyc = 0, last_rise = 0, last_int = 0, rises = 0;
  logic tick_d = 1'b0;
  logic [27:0] exp_q[$];

  halfslot_clock #(.HALF_SLOT(HS), .LP_DIV(LP), .TICK_W(2)) uut (
    .clk(clk), .rst_n(rst_n), .strap(strap), .lp_pulse(lp_pulse),
    .cmd_load(cmd_load), .load_en(load_en), .load_val(load_val),
    .pd_req(pd_req), .wake_mark(wake_mark), .sync_strobe(sync_strobe),
    .slave_pos(slave_pos), .native_cnt(native_cnt), .tick(tick),
    .hf_on(hf_on), .ready(ready), .skew(skew), .skew_valid(skew_valid),
    .skew_ovf(skew_ovf)
  );

  always #2.5 clk = ~clk;

  task automatic check(string req, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // Monitor: scoreboard of expected counts, popped on each tick rise
  always @(negedge clk) begin
    cyc++;
    if (rst_n && tick && !tick_d) begin
      last_int  = cyc - last_rise;
      last_rise = cyc;
      rises++;
      if (exp_q.size() > 0) check("R3 count at tick", native_cnt, exp_q.pop_front());
    end
    tick_d = tick;
  end

  // Slow oscillator strobe, free running
  initial begin
    forever begin
      repeat (LP_PERIOD - 1) @(negedge clk);
      lp_pulse = 1'b1;
      @(negedge clk);
      lp_pulse = 1'b0;
    end
  end

  initial begin
    #(150000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_rise();
    int r0 = rises;
    while (rises == r0) step();
  endtask

  task automatic do_reset(logic [1:0] s);
    rst_n = 1'b0;
    strap = s;
    exp_q.delete();
    repeat (4) step();
    rst_n = 1'b1;
  endtask

  task automatic interval_case(logic [1:0] s, logic [1:0] later, int exp_int);
    do_reset(s);
    step();
    strap = later;
    wait_rise();
    wait_rise();
    check("R2 increment interval", last_int, exp_int);
  endtask

  task automatic skew_case(bit odd, int spos, int exp_skew, int exp_ovf);
    wait_rise();
    while (native_cnt[0] != odd) wait_rise();
    slave_pos = 5'(spos);
    sync_strobe = 1'b1;
    step();
    sync_strobe = 1'b0;
    check("R9 skew_valid", skew_valid, 1);
    check("R9/R10 skew value", $signed(skew), exp_skew);
    check("R10 skew_ovf", skew_ovf, exp_ovf);
    step();
    check("R9 skew_valid single cycle", skew_valid, 0);
  endtask

  initial begin
    logic [27:0] c;
    logic [4:0]  held;
    // R1 reset state
    do_reset(2'b00);
    check("R1 count", native_cnt, 0);
    check("R1 tick", tick, 0);
    check("R1 hf_on", hf_on, 1);
    check("R1 ready", ready, 1);
    check("R1 skew flags", {skew_valid, skew_ovf}, 0);

    // R3 consecutive increments
    exp_q.push_back(28'd1);
    exp_q.push_back(28'd2);
    exp_q.push_back(28'd3);
    repeat (3) wait_rise();
    check("R2 interval div2", last_int, 2 * HS);
    check("R3 tick width", tick, 1);
    step();
    check("R3 tick still high", tick, 1);
    step();
    check("R3 tick low after width", tick, 0);

    // R2 each strap code, with a strap change after release
    interval_case(2'b01, 2'b10, 3 * HS);
    interval_case(2'b10, 2'b00, 4 * HS);
    interval_case(2'b11, 2'b10, 2 * HS);

    do_reset(2'b00);
    wait_rise();
    c = native_cnt;
    // R5 load with flag clear
    cmd_load = 1'b1; load_en = 1'b0; load_val = 12'h555;
    step();
    cmd_load = 1'b0;
    step();
    check("R5 load ignored", native_cnt, c);

    // R4 load low bits, R6 carry out of low field
    cmd_load = 1'b1; load_en = 1'b1; load_val = 12'hFFF;
    step();
    cmd_load = 1'b0; load_en = 1'b0;
    check("R4 loaded value", native_cnt, {c[27:12], 12'hFFF});
    exp_q.push_back({c[27:12] + 16'd1, 12'h000});
    exp_q.push_back({c[27:12] + 16'd1, 12'h001});
    wait_rise();
    check("R6 carry into bit 12", native_cnt[12], 1);
    wait_rise();

    // R9 / R10 skew cases (master position 0 or HS at the strobe)
    skew_case(1'b1, 13, 3, 0);
    skew_case(1'b0, 9, 9, 0);
    skew_case(1'b1, 1, -9, 0);
    skew_case(1'b1, 0, -9, 1);
    skew_case(1'b0, 31, 9, 1);
    skew_case(1'b1, 12, 2, 1);

    // R7 / R8 / R11 sleep and wake
    wait_rise();
    c = native_cnt;
    wake_mark = 12'(c[11:0] + 12'd3);
    pd_req = 1'b1;
    step();
    pd_req = 1'b0;
    check("R7 hf_on low", hf_on, 0);
    check("R7 ready low", ready, 0);
    for (int k = 1; k <= 6; k++) exp_q.push_back(c + 28'(k));
    wait_rise();
    held = skew;
    slave_pos = 5'd4;
    sync_strobe = 1'b1;
    step();
    sync_strobe = 1'b0;
    check("R11 strobe ignored valid", skew_valid, 0);
    check("R11 skew unchanged", skew, held);
    wait_rise();
    check("R7 sleep interval", last_int, LP * LP_PERIOD);
    check("R7 still asleep", hf_on, 0);
    wait_rise();
    check("R8 wake at mark", hf_on, 1);
    check("R8 not ready yet", ready, 0);
    wait_rise();
    check("R8 high rate restart", last_int, 2 * HS);
    wait_rise();
    check("R8 ready after two", ready, 0);
    wait_rise();
    check("R8 ready after three", ready, 1);
    check("R8 scoreboard drained", exp_q.size(), 0);

    finish_run();
  end

endmodule